// File: doc/BRIEF.md
# Weighted Physical Register Occupancy Tracker

This block sits in the rename stage of an out-of-order core and keeps a running count of how many physical registers are in use in each of several register files. Every architectural register is bound, through a small loadable table, to a file index and a weight (the number of physical registers one write to it consumes). File 0 is an aggregate: it is charged for every allocation and release, whatever dedicated file the register belongs to. A register bound to file 0 charges only the aggregate.

Rename logic sends one allocation and one release per cycle as single-cycle strobes. Each strobe carries the register and three flags: zero idiom, eliminated move, and narrow write kept inside a wider register. A flagged write costs nothing. Before it renames a group of destinations, the front end asks whether the group fits. A combinational query over a few lanes returns one stall bit per file. A file with capacity zero has no limit. A group that alone exceeds a file's whole capacity is trimmed to that capacity, so it can still proceed once the file drains. The counters and the table are loaded from plain configuration pins. Requests are strobes and the block never pushes back, so there is no valid/ready pair: a strobe is taken in the cycle it is high.

Top module: `phys_reg_tracker`

## Requirements
- R1: After reset every count is zero, every file capacity is zero, every register maps to file 0 with weight 1, the error flag is low and the stall mask is zero.
- R2: An unflagged allocation adds the register's weight to its mapped file and to file 0 (once only when the mapped file is 0); the count changes on the clock edge that samples the strobe.
- R3: An unflagged release subtracts the register's weight from the same files an allocation would charge.
- R4: An allocation or release with flag bit 0 (zero idiom), bit 1 (eliminated move) or bit 2 (narrow write) set leaves every count unchanged.
- R5: An allocation and a release in the same cycle are both applied, and each file gets the net change.
- R6: A release that would take a count below zero leaves it at zero and sets the error flag, which stays set until reset.
- R7: Stall bit i is set when query lanes are enabled, the summed weight of the enabled lanes charged to file i is nonzero, and used count plus that demand exceeds the capacity; with no lane enabled the mask is zero. The mask is combinational in the current counts.
- R8: A file with capacity zero never sets its stall bit.
- R9: A demand larger than a file's capacity is reduced to the capacity before the comparison.
- R10: A table write (register, file, weight) or a capacity write is used from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_map_we | input | 1 | Write a table entry |
| cfg_map_reg | input | AW | Register whose entry is written |
| cfg_map_file | input | FW | File index for that register |
| cfg_map_cost | input | COST_W | Weight for that register |
| cfg_cap_we | input | 1 | Write a file capacity |
| cfg_cap_file | input | FW | File whose capacity is written |
| cfg_cap_val | input | CNT_W | Capacity, zero for no limit |
| alloc_valid | input | 1 | Allocation strobe |
| alloc_reg | input | AW | Register being written |
| alloc_flags | input | 3 | {narrow, eliminated, zero idiom} |
| free_valid | input | 1 | Release strobe |
| free_reg | input | AW | Register being retired |
| free_flags | input | 3 | {narrow, eliminated, zero idiom} |
| qry_en | input | QN | Enabled query lanes |
| qry_reg | input | QN*AW | Query registers, lane 0 in the low bits |
| stall_mask | output | NF | One stall bit per file |
| used_count | output | NF*CNT_W | Used counts, file 0 in the low bits |
| err_underflow | output | 1 | Sticky underflow flag |

## Verification
The assertions assume the strobe inputs are never unknown once reset is released. They also assume configuration writes do not land in the same cycle as a request that depends on them. The counts they watch only move on allocation or release strobes, and the error flag only rises on a release. The bench drives every input on the falling edge and writes the table and capacities only in cycles with no strobe. It keeps the aggregate count well below its width limit, so no overflow can hide a fault that an assertion would otherwise catch.

// File: rtl/prt_pkg.sv
package prt_pkg;
  localparam int FLAG_W = 3;

  typedef struct packed {
    logic narrow;
    logic elim;
    logic zero;
  } wr_flags_t;

  function automatic logic charges(input logic valid, input wr_flags_t fl);
    return valid && !fl.zero && !fl.elim && !fl.narrow;
  endfunction
endpackage

// File: rtl/prt_map_table.sv
module prt_map_table #(
  parameter int NUM_ARCH = 16,
  parameter int AW       = 4,
  parameter int FW       = 2,
  parameter int COST_W   = 2,
  parameter int NLOOK    = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [AW-1:0]           wr_reg,
  input  logic [FW-1:0]           wr_file,
  input  logic [COST_W-1:0]       wr_cost,
  input  logic [NLOOK*AW-1:0]     lk_reg,
  output logic [NLOOK*FW-1:0]     lk_file,
  output logic [NLOOK*COST_W-1:0] lk_cost
);
  logic [FW-1:0]     file_q [NUM_ARCH];
  logic [COST_W-1:0] cost_q [NUM_ARCH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_ARCH; i++) begin
        file_q[i] <= '0;
        cost_q[i] <= COST_W'(1);
      end
    end else if (we) begin
      file_q[wr_reg] <= wr_file;
      cost_q[wr_reg] <= wr_cost;
    end
  end

  for (genvar l = 0; l < NLOOK; l++) begin : g_look
    assign lk_file[l*FW +: FW]         = file_q[lk_reg[l*AW +: AW]];
    assign lk_cost[l*COST_W +: COST_W] = cost_q[lk_reg[l*AW +: AW]];
  end
endmodule

// File: rtl/prt_file_slot.sv
module prt_file_slot #(
  parameter int CNT_W  = 6,
  parameter int COST_W = 2,
  parameter int DW     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_we,
  input  logic [CNT_W-1:0]  cap_val,
  input  logic [COST_W-1:0] add,
  input  logic [COST_W-1:0] sub,
  input  logic [DW-1:0]     demand,
  output logic [CNT_W-1:0]  used,
  output logic              stall,
  output logic              uflow
);
  localparam int XW = ((DW > CNT_W) ? DW : CNT_W) + 1;

  logic [CNT_W-1:0] used_q, cap_q, used_d;
  logic [CNT_W:0]   grown;
  logic [XW-1:0]    dem_x, cap_x, trimmed;

  always_comb begin
    grown  = {1'b0, used_q} + (CNT_W + 1)'(add);
    uflow  = grown < (CNT_W + 1)'(sub);
    used_d = uflow ? '0 : CNT_W'(grown - (CNT_W + 1)'(sub));
  end

  always_comb begin
    dem_x   = XW'(demand);
    cap_x   = XW'(cap_q);
    trimmed = (dem_x > cap_x) ? cap_x : dem_x;
    stall   = (cap_q != '0) && (demand != '0) && ((XW'(used_q) + trimmed) > cap_x);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      used_q <= '0;
      cap_q  <= '0;
    end else begin
      used_q <= used_d;
      if (cap_we) cap_q <= cap_val;
    end
  end

  assign used = used_q;
endmodule

// File: rtl/phys_reg_tracker.sv
module phys_reg_tracker #(
  parameter int NF       = 3,
  parameter int NUM_ARCH = 16,
  parameter int COST_W   = 2,
  parameter int CNT_W    = 6,
  parameter int QN       = 2,
  localparam int AW      = $clog2(NUM_ARCH),
  localparam int FW      = (NF > 1) ? $clog2(NF) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_map_we,
  input  logic [AW-1:0]       cfg_map_reg,
  input  logic [FW-1:0]       cfg_map_file,
  input  logic [COST_W-1:0]   cfg_map_cost,
  input  logic                cfg_cap_we,
  input  logic [FW-1:0]       cfg_cap_file,
  input  logic [CNT_W-1:0]    cfg_cap_val,
  input  logic                alloc_valid,
  input  logic [AW-1:0]       alloc_reg,
  input  logic [2:0]          alloc_flags,
  input  logic                free_valid,
  input  logic [AW-1:0]       free_reg,
  input  logic [2:0]          free_flags,
  input  logic [QN-1:0]       qry_en,
  input  logic [QN*AW-1:0]    qry_reg,
  output logic [NF-1:0]       stall_mask,
  output logic [NF*CNT_W-1:0] used_count,
  output logic                err_underflow
);
  import prt_pkg::*;

  localparam int NLOOK = 2 + QN;
  localparam int DW    = COST_W + $clog2(QN + 1);

  logic [NLOOK*AW-1:0]     lk_reg;
  logic [NLOOK*FW-1:0]     lk_file;
  logic [NLOOK*COST_W-1:0] lk_cost;
  logic                    a_chg, f_chg;
  logic [NF-1:0]           uflow;
  logic                    err_q;

  assign lk_reg = {qry_reg, free_reg, alloc_reg};
  assign a_chg  = charges(alloc_valid, wr_flags_t'(alloc_flags));
  assign f_chg  = charges(free_valid, wr_flags_t'(free_flags));

  prt_map_table #(
    .NUM_ARCH(NUM_ARCH), .AW(AW), .FW(FW), .COST_W(COST_W), .NLOOK(NLOOK)
  ) u_map (
    .clk(clk), .rst_n(rst_n),
    .we(cfg_map_we), .wr_reg(cfg_map_reg), .wr_file(cfg_map_file), .wr_cost(cfg_map_cost),
    .lk_reg(lk_reg), .lk_file(lk_file), .lk_cost(lk_cost)
  );

  for (genvar f = 0; f < NF; f++) begin : g_file
    logic              hit_a, hit_f;
    logic [COST_W-1:0] add, sub;
    logic [DW-1:0]     demand;

    assign hit_a = (f == 0) || (lk_file[0 +: FW] == FW'(f));
    assign hit_f = (f == 0) || (lk_file[FW +: FW] == FW'(f));
    assign add   = (a_chg && hit_a) ? lk_cost[0 +: COST_W] : '0;
    assign sub   = (f_chg && hit_f) ? lk_cost[COST_W +: COST_W] : '0;

    always_comb begin
      demand = '0;
      for (int q = 0; q < QN; q++) begin
        if (qry_en[q] && ((f == 0) || (lk_file[(2+q)*FW +: FW] == FW'(f))))
          demand = demand + DW'(lk_cost[(2+q)*COST_W +: COST_W]);
      end
    end

    prt_file_slot #(.CNT_W(CNT_W), .COST_W(COST_W), .DW(DW)) u_slot (
      .clk(clk), .rst_n(rst_n),
      .cap_we(cfg_cap_we && (cfg_cap_file == FW'(f))), .cap_val(cfg_cap_val),
      .add(add), .sub(sub), .demand(demand),
      .used(used_count[f*CNT_W +: CNT_W]), .stall(stall_mask[f]), .uflow(uflow[f])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_q | (|uflow);
  end

  assign err_underflow = err_q;
endmodule

// File: rtl/prt_checker.sv
module prt_checker #(
  parameter int NF    = 3,
  parameter int CNT_W = 6,
  parameter int QN    = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                alloc_valid,
  input logic [2:0]          alloc_flags,
  input logic                free_valid,
  input logic [2:0]          free_flags,
  input logic [QN-1:0]       qry_en,
  input logic [NF-1:0]       stall_mask,
  input logic [NF*CNT_W-1:0] used_count,
  input logic                err_underflow
);
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!alloc_valid && !free_valid) |=> $stable(used_count));

  p_zero_alloc_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && alloc_flags[0] && !free_valid) |=> $stable(used_count));

  p_elim_free_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (free_valid && free_flags[1] && !alloc_valid) |=> $stable(used_count));

  p_err_needs_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_underflow) |-> $past(free_valid));

  p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    err_underflow |=> err_underflow);

  p_no_lane_no_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (qry_en == '0) |-> (stall_mask == '0));
endmodule

bind phys_reg_tracker prt_checker #(.NF(NF), .CNT_W(CNT_W), .QN(QN)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .alloc_valid(alloc_valid), .alloc_flags(alloc_flags),
  .free_valid(free_valid), .free_flags(free_flags),
  .qry_en(qry_en), .stall_mask(stall_mask),
  .used_count(used_count), .err_underflow(err_underflow)
);

// File: tb/phys_reg_tracker_bench.sv
module phys_reg_tracker_bench;
  localparam int NF = 3, NUM_ARCH = 16, COST_W = 2, CNT_W = 6, QN = 2;
  localparam int AW = 4, FW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_map_we = 0, cfg_cap_we = 0;
  logic [AW-1:0] cfg_map_reg = '0;
  logic [FW-1:0] cfg_map_file = '0, cfg_cap_file = '0;
  logic [COST_W-1:0] cfg_map_cost = '0;
  logic [CNT_W-1:0] cfg_cap_val = '0;
  logic alloc_valid = 0, free_valid = 0;
  logic [AW-1:0] alloc_reg = '0, free_reg = '0;
  logic [2:0] alloc_flags = '0, free_flags = '0;
  logic [QN-1:0] qry_en = '0;
  logic [QN*AW-1:0] qry_reg = '0;
  logic [NF-1:0] stall_mask;
  logic [NF*CNT_W-1:0] used_count;
  logic err_underflow;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int mfile [NUM_ARCH];
  int mcost [NUM_ARCH];
  int mcap [NF];
  int mused [NF];

  always #2.5 clk = ~clk;

  phys_reg_tracker #(.NF(NF), .NUM_ARCH(NUM_ARCH), .COST_W(COST_W), .CNT_W(CNT_W), .QN(QN))
  u_phys_reg_tracker (.*);

  function automatic int used_of(int f);
    return int'(used_count[f*CNT_W +: CNT_W]);
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_counts(string tag, int e0, int e1, int e2);
    chk({tag, " file0"}, used_of(0), e0);
    chk({tag, " file1"}, used_of(1), e1);
    chk({tag, " file2"}, used_of(2), e2);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // model of R2..R6, applied alongside every request
  task automatic model_step(bit av, int ar, int af, bit fv, int fr, int ff);
    for (int f = 0; f < NF; f++) begin
      int ad = 0, sb = 0, t;
      if (av && af == 0 && (f == 0 || mfile[ar] == f)) ad = mcost[ar];
      if (fv && ff == 0 && (f == 0 || mfile[fr] == f)) sb = mcost[fr];
      t = mused[f] + ad;
      mused[f] = (t < sb) ? 0 : t - sb;
    end
  endtask

  function automatic int model_mask(int en, int r0, int r1);
    int m = 0;
    for (int f = 0; f < NF; f++) begin
      int d = 0;
      if (en[0] && (f == 0 || mfile[r0] == f)) d += mcost[r0];
      if (en[1] && (f == 0 || mfile[r1] == f)) d += mcost[r1];
      if (mcap[f] != 0 && d != 0) begin
        if (d > mcap[f]) d = mcap[f];
        if (mused[f] + d > mcap[f]) m |= (1 << f);
      end
    end
    return m;
  endfunction

  task automatic op(bit av, int ar, int af, bit fv, int fr, int ff);
    alloc_valid = av; alloc_reg = AW'(ar); alloc_flags = 3'(af);
    free_valid = fv; free_reg = AW'(fr); free_flags = 3'(ff);
    @(negedge clk);
    alloc_valid = 0; free_valid = 0; alloc_flags = 0; free_flags = 0;
    model_step(av, ar, af, fv, fr, ff);
  endtask

  task automatic set_map(int r, int f, int c);
    cfg_map_we = 1; cfg_map_reg = AW'(r); cfg_map_file = FW'(f); cfg_map_cost = COST_W'(c);
    @(negedge clk);
    cfg_map_we = 0;
    mfile[r] = f; mcost[r] = c;
  endtask

  task automatic set_cap(int f, int v);
    cfg_cap_we = 1; cfg_cap_file = FW'(f); cfg_cap_val = CNT_W'(v);
    @(negedge clk);
    cfg_cap_we = 0;
    mcap[f] = v;
  endtask

  function automatic int query(int en, int r0, int r1);
    qry_en = QN'(en);
    qry_reg = {AW'(r1), AW'(r0)};
    return 0;
  endfunction

  task automatic chk_mask(string tag, int en, int r0, int r1, int exp);
    void'(query(en, r0, r1));
    #1;
    chk(tag, int'(stall_mask), exp);
    qry_en = '0;
  endtask

  task automatic t_reset();
    chk_counts("R1 reset", 0, 0, 0);
    chk("R1 err after reset", int'(err_underflow), 0);
    chk_mask("R1 no stall, unbounded files", 3, 1, 2, 0);
  endtask

  task automatic t_config_alloc();
    set_map(1, 1, 2); set_map(2, 2, 1); set_map(3, 0, 3);
    set_cap(1, 4); set_cap(0, 8);
    op(1, 1, 0, 0, 0, 0);
    chk_counts("R2/R10 alloc reg1", 2, 2, 0);
    op(1, 3, 0, 0, 0, 0);
    chk_counts("R2 alloc file0-only reg3", 5, 2, 0);
  endtask

  task automatic t_flags();
    op(1, 1, 1, 0, 0, 0);
    chk_counts("R4 zero-idiom alloc", 5, 2, 0);
    op(1, 1, 2, 0, 0, 0);
    chk_counts("R4 eliminated alloc", 5, 2, 0);
    op(1, 1, 4, 0, 0, 0);
    chk_counts("R4 narrow alloc", 5, 2, 0);
    op(0, 0, 0, 1, 1, 2);
    chk_counts("R4 eliminated free", 5, 2, 0);
    op(0, 0, 0, 1, 3, 4);
    chk_counts("R4 narrow free", 5, 2, 0);
  endtask

  task automatic t_free_simul();
    op(0, 0, 0, 1, 3, 0);
    chk_counts("R3 free reg3", 2, 2, 0);
    op(1, 2, 0, 1, 1, 0);
    chk_counts("R5 alloc+free same cycle", 1, 0, 1);
  endtask

  task automatic t_query();
    chk_mask("R7 reg1 pair fits", 3, 1, 1, 0);
    op(1, 1, 0, 0, 0, 0);
    chk_mask("R7 reg1 pair stalls file1", 3, 1, 1, 3'b010);
    chk_mask("R7 single lane fits", 1, 1, 0, 0);
    chk_mask("R8 unbounded file2 never stalls", 3, 2, 2, 0);
    set_cap(1, 3);
    chk_mask("R9 trimmed demand still stalls", 3, 1, 1, 3'b010);
    op(0, 0, 0, 1, 1, 0);
    chk_mask("R9 trimmed demand fits empty file", 3, 1, 1, 0);
    set_cap(0, 2);
    chk_mask("R9 file0 trimmed demand stalls", 1, 3, 0, 3'b001);
    set_cap(0, 8);
  endtask

  task automatic t_underflow();
    op(0, 0, 0, 1, 2, 0);
    chk_counts("R3 free reg2 to zero", 0, 0, 0);
    chk("R6 no error yet", int'(err_underflow), 0);
    op(0, 0, 0, 1, 2, 0);
    chk_counts("R6 saturate at zero", 0, 0, 0);
    chk("R6 error set", int'(err_underflow), 1);
    @(negedge clk);
    chk("R6 error sticky", int'(err_underflow), 1);
  endtask

  task automatic t_random();
    for (int i = 0; i < 300; i++) begin
      int ar = $urandom_range(0, 5), fr = $urandom_range(0, 5);
      int r0 = $urandom_range(0, 5), r1 = $urandom_range(0, 5);
      int en = $urandom_range(0, 3);
      bit av = $urandom_range(0, 1) && (mused[0] < 50);
      bit fv = $urandom_range(0, 1);
      int af = ($urandom_range(0, 3) == 0) ? (1 << $urandom_range(0, 2)) : 0;
      int ff = ($urandom_range(0, 3) == 0) ? (1 << $urandom_range(0, 2)) : 0;
      chk_mask("R7 random query", en, r0, r1, model_mask(en, r0, r1));
      op(av, ar, af, fv, fr, ff);
      chk_counts("R5 random sequence", mused[0], mused[1], mused[2]);
    end
  endtask

  initial begin
    for (int i = 0; i < NUM_ARCH; i++) begin mfile[i] = 0; mcost[i] = 1; end
    for (int f = 0; f < NF; f++) begin mcap[f] = 0; mused[f] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_config_alloc();
    t_flags();
    t_free_simul();
    t_query();
    t_underflow();
    t_random();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule